// File: doc/BRIEF.md
# ATAPI Task-Register File with Self-Clearing Sequence Triggers

This block holds the seven byte-wide ATAPI task registers, a drive-side device control byte and a small mode byte. All of them sit behind a local microprocessor port with a synchronous write strobe and a combinational read. A separate write-only kick register starts short automatic operations on the task registers. Each kick bit stays pending until its operation is finished and then clears itself. The current pending state is visible on a dedicated output.

Three operations exist:

- **Soft-reset release.** Drops the soft-reset bit of the device control byte.
- **Seek-complete report.** Sets the seek-complete status bit. When automatic busy is enabled, this step is bracketed by raising and lowering the busy bit, with one step per clock.
- **Signature load.** Writes the fixed device signature into the task registers. It keeps the busy and seek-complete status bits and leaves the drive-select register alone.

When several kicks are pending, they are served one at a time in a fixed priority order. A sequence step overrides any microprocessor write aimed at the same register in the same cycle.

Top module: `atapi_taskfile_seq`

## Requirements
- R1: While reset is applied and after it is released, every readable register reads 00h and `kick_pending` is 000b.
- R2: A write to 31h..37h (error/features, interrupt reason, sector number, byte count low, byte count high, drive select, status), 18h (mode) or 3Eh (device control) is read back at the same address from the next cycle on. Reads of 17h, or of any other unmapped address, return 00h.
- R3: A write to 17h ORs data bits 6, 5 and 4 into `kick_pending` bits 2 (soft-reset release), 1 (seek complete) and 0 (signature). These bits are visible the cycle after the write. Data bit 7 and bits 3..0 have no effect.
- R4: The cycle after the soft-reset-release bit is pending, device control bit 2 becomes 0, every other device control bit is unchanged, and `kick_pending` bit 2 clears.
- R5: With mode bit 1 = 1, a pending seek-complete kick changes status on three consecutive cycles: bit 7 (busy) goes to 1, then bit 4 (seek complete) goes to 1, then bit 7 goes to 0. `kick_pending` bit 1 clears one cycle after busy falls.
- R6: With mode bit 1 = 0, a pending seek-complete kick sets status bit 4 one cycle after it is pending. Status bit 7 is left as it was, and `kick_pending` bit 1 clears in that same cycle.
- R7: One cycle after a signature kick is pending, the following values are loaded: 31h=01h, 32h=01h, 33h=01h, 34h=14h, 35h=EBh. Status keeps bits 7 and 4 and has all other bits cleared. 36h is unchanged, and `kick_pending` bit 0 clears.
- R8: Only one operation is served per cycle. The order is soft-reset release first, then signature, then seek complete. A started busy-bracketed seek runs to its end.
- R9: A microprocessor write to a register that a sequence step updates in the same cycle is overridden by the sequence result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | Microprocessor write strobe |
| cpu_addr | input | AW (8) | Register address for read and write |
| cpu_wdata | input | DW (8) | Write data |
| cpu_rdata | output | DW (8) | Combinational read data for `cpu_addr` |
| kick_pending | output | 3 | Pending kicks: bit 2 soft-reset release, bit 1 seek complete, bit 0 signature |

## Verification
Read data follows `cpu_addr` within the same cycle. A register write shows one clock edge after its strobe. A kick shows in `kick_pending` one edge after the write to 17h. Its soft-reset-release, signature or plain seek-complete effect lands one edge later. The busy-bracketed seek moves status on each of the next three edges and clears its pending bit on the fourth.

The bench drives all inputs on the falling edge and reads in the middle of the low phase. It walks a fixed number of falling edges that matches these counts before each comparison. A reference model in bench functions supplies every expected byte, including for the seeded random write and kick mix.

// File: rtl/atapi_tf_pkg.sv
package atapi_tf_pkg;

  // task register slots, offset from the task base address
  localparam int unsigned IDX_ERR  = 0;
  localparam int unsigned IDX_IRR  = 1;
  localparam int unsigned IDX_SNUM = 2;
  localparam int unsigned IDX_BCL  = 3;
  localparam int unsigned IDX_BCH  = 4;
  localparam int unsigned IDX_DRV  = 5;
  localparam int unsigned IDX_STAT = 6;

  // bit positions that neighbouring logic decodes
  localparam int unsigned STAT_BUSY  = 7;
  localparam int unsigned STAT_SEEK  = 4;
  localparam int unsigned DEVC_SRST  = 2;
  localparam int unsigned MODE_ABUSY = 1;

  // kick register data bits and pending vector slots
  localparam int unsigned KICK_LSB   = 4;
  localparam int unsigned PEND_SIG   = 0;
  localparam int unsigned PEND_SEEK  = 1;
  localparam int unsigned PEND_CLR   = 2;
  localparam int unsigned NKICK      = 3;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_MARK   = 2'd1,
    SQ_UNBUSY = 2'd2,
    SQ_FINISH = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic clr_srst;
    logic sig_load;
    logic set_busy;
    logic set_seek;
    logic clr_busy;
  } seq_act_t;

endpackage

// File: rtl/kick_reg.sv
module kick_reg
  import atapi_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NKICK-1:0] kick_bits,
  input  logic [NKICK-1:0] done,
  output logic [NKICK-1:0] pend
);

  logic [NKICK-1:0] pend_q, pend_n;

  always_comb begin
    pend_n = pend_q & ~done;
    if (wr_en) begin
      pend_n = pend_n | kick_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  // a pending bit may only appear after a write to the kick register
  assert_rise_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) != '0) |-> $past(wr_en));

endmodule

// File: rtl/kick_seq.sv
module kick_seq
  import atapi_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKICK-1:0] pend,
  input  logic             auto_busy,
  output seq_act_t         act,
  output logic [NKICK-1:0] done
);

  seq_state_t state_q, state_n;

  always_comb begin
    state_n = state_q;
    act     = '0;
    done    = '0;
    case (state_q)
      SQ_IDLE: begin
        if (pend[PEND_CLR]) begin
          act.clr_srst   = 1'b1;
          done[PEND_CLR] = 1'b1;
        end else if (pend[PEND_SIG]) begin
          act.sig_load   = 1'b1;
          done[PEND_SIG] = 1'b1;
        end else if (pend[PEND_SEEK]) begin
          if (auto_busy) begin
            act.set_busy = 1'b1;
            state_n      = SQ_MARK;
          end else begin
            act.set_seek    = 1'b1;
            done[PEND_SEEK] = 1'b1;
          end
        end
      end
      SQ_MARK: begin
        act.set_seek = 1'b1;
        state_n      = SQ_UNBUSY;
      end
      SQ_UNBUSY: begin
        act.clr_busy = 1'b1;
        state_n      = SQ_FINISH;
      end
      default: begin
        done[PEND_SEEK] = 1'b1;
        state_n         = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  // never more than one register action in a cycle
  assert_single_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  // the busy window cannot be entered without a pending seek kick
  assert_busy_from_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act.set_busy |-> pend[PEND_SEEK]);

endmodule

// File: rtl/task_file.sv
module task_file
  import atapi_tf_pkg::*;
#(
  parameter int unsigned    AW        = 8,
  parameter int unsigned    DW        = 8,
  parameter int unsigned    NTASK     = 7,
  parameter logic [AW-1:0]  TASK_BASE = 8'h31,
  parameter logic [AW-1:0]  MODE_ADDR = 8'h18,
  parameter logic [AW-1:0]  DEVC_ADDR = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  seq_act_t      act,
  output logic [DW-1:0] rdata,
  output logic          auto_busy
);

  logic [NTASK-1:0][DW-1:0] task_q, task_n;
  logic [DW-1:0]            mode_q, mode_n;
  logic [DW-1:0]            devc_q, devc_n;

  function automatic logic [DW-1:0] sig_word(input int unsigned idx,
                                             input logic [DW-1:0] cur);
    logic [DW-1:0] w;
    w = cur;
    case (idx)
      IDX_ERR, IDX_IRR, IDX_SNUM: w = DW'(8'h01);
      IDX_BCL:                    w = DW'(8'h14);
      IDX_BCH:                    w = DW'(8'hEB);
      IDX_STAT: begin
        w            = '0;
        w[STAT_BUSY] = cur[STAT_BUSY];
        w[STAT_SEEK] = cur[STAT_SEEK];
      end
      default:                    w = cur;
    endcase
    return w;
  endfunction

  always_comb begin
    task_n = task_q;
    mode_n = mode_q;
    devc_n = devc_q;
    if (cpu_we && cpu_addr == MODE_ADDR) mode_n = cpu_wdata;
    if (cpu_we && cpu_addr == DEVC_ADDR) devc_n = cpu_wdata;
    for (int i = 0; i < NTASK; i++) begin
      if (cpu_we && cpu_addr == TASK_BASE + AW'(i)) task_n[i] = cpu_wdata;
      // sequence results take precedence over the microprocessor write
      if (act.sig_load && i != int'(IDX_DRV)) task_n[i] = sig_word(i, task_q[i]);
    end
    if (act.set_busy) begin
      task_n[IDX_STAT]            = task_q[IDX_STAT];
      task_n[IDX_STAT][STAT_BUSY] = 1'b1;
    end
    if (act.set_seek) begin
      task_n[IDX_STAT]            = task_q[IDX_STAT];
      task_n[IDX_STAT][STAT_SEEK] = 1'b1;
    end
    if (act.clr_busy) begin
      task_n[IDX_STAT]            = task_q[IDX_STAT];
      task_n[IDX_STAT][STAT_BUSY] = 1'b0;
    end
    if (act.clr_srst) begin
      devc_n            = devc_q;
      devc_n[DEVC_SRST] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_q <= '0;
      mode_q <= '0;
      devc_q <= '0;
    end else begin
      task_q <= task_n;
      mode_q <= mode_n;
      devc_q <= devc_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (cpu_addr == MODE_ADDR) rdata = mode_q;
    if (cpu_addr == DEVC_ADDR) rdata = devc_q;
    for (int i = 0; i < NTASK; i++) begin
      if (cpu_addr == TASK_BASE + AW'(i)) rdata = task_q[i];
    end
  end

  assign auto_busy = mode_q[MODE_ABUSY];

  assert_srst_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act.clr_srst |=> !devc_q[DEVC_SRST]);

  assert_seek_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act.set_seek |=> task_q[IDX_STAT][STAT_SEEK]);

  assert_busy_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act.clr_busy |=> !task_q[IDX_STAT][STAT_BUSY]);

  assert_drive_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act.sig_load && !(cpu_we && cpu_addr == TASK_BASE + AW'(IDX_DRV)))
      |=> $stable(task_q[IDX_DRV]));

  assert_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act.sig_load && cpu_we && cpu_addr == TASK_BASE + AW'(IDX_BCH))
      |=> task_q[IDX_BCH] == DW'(8'hEB));

endmodule

// File: rtl/atapi_taskfile_seq.sv
module atapi_taskfile_seq
  import atapi_tf_pkg::*;
#(
  parameter int unsigned   AW        = 8,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] KICK_ADDR = 8'h17,
  parameter logic [AW-1:0] MODE_ADDR = 8'h18,
  parameter logic [AW-1:0] TASK_BASE = 8'h31,
  parameter logic [AW-1:0] DEVC_ADDR = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [2:0]    kick_pending
);

  localparam int unsigned NTASK = IDX_STAT + 1;

  logic             rst_meta_q, rst_sync_q;
  logic             kick_wr;
  logic             auto_busy;
  logic [NKICK-1:0] pend, done;
  seq_act_t         act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign kick_wr = cpu_we && (cpu_addr == KICK_ADDR);

  kick_reg u_kick (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (kick_wr),
    .kick_bits (cpu_wdata[KICK_LSB +: NKICK]),
    .done      (done),
    .pend      (pend)
  );

  kick_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .pend      (pend),
    .auto_busy (auto_busy),
    .act       (act),
    .done      (done)
  );

  task_file #(
    .AW        (AW),
    .DW        (DW),
    .NTASK     (NTASK),
    .TASK_BASE (TASK_BASE),
    .MODE_ADDR (MODE_ADDR),
    .DEVC_ADDR (DEVC_ADDR)
  ) u_file (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .act       (act),
    .rdata     (cpu_rdata),
    .auto_busy (auto_busy)
  );

  assign kick_pending = pend;

endmodule

// File: tb/atapi_taskfile_seq_tb.sv
module atapi_taskfile_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_we;
  logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [2:0] kick_pending;

  int nchk  = 0;
  int nfail = 0;

  logic [7:0] m_task [7];
  logic [7:0] m_mode, m_devc;

  always #(CLK_PERIOD/2) clk = ~clk;

  atapi_taskfile_seq u_dut (
    .clk (clk), .rst_n (rst_n), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .kick_pending (kick_pending)
  );

  function automatic logic [7:0] sig_exp(input int idx, input logic [7:0] cur);
    case (idx)
      0, 1, 2: return 8'h01;
      3:       return 8'h14;
      4:       return 8'hEB;
      6:       return cur & 8'h90;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] seek_exp(input logic [7:0] st, input logic abe);
    return abe ? ((st | 8'h10) & 8'h7F) : (st | 8'h10);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    if (a >= 8'h31 && a <= 8'h37) m_task[a - 8'h31] = d;
    if (a == 8'h18) m_mode = d;
    if (a == 8'h3E) m_devc = d;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(8'h31 + 8'(i), d);
      chk(req, $sformatf("task %02h", 8'h31 + 8'(i)), d, m_task[i]);
    end
    rd(8'h18, d); chk(req, "mode", d, m_mode);
    rd(8'h3E, d); chk(req, "devctl", d, m_devc);
  endtask

  task automatic chk_pend(input string req, input logic [2:0] exp);
    chk(req, "kick_pending", {5'b0, kick_pending}, {5'b0, exp});
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [7:0] d;
    rd(8'h37, d);
    chk(req, "status", d, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [31:0] r;
    r = $urandom(32'h5EED_0017);
    cpu_we = 1'b0; cpu_addr = 8'h00; cpu_wdata = 8'h00;
    for (int i = 0; i < 7; i++) m_task[i] = 8'h00;
    m_mode = 8'h00; m_devc = 8'h00;
    rst_n = 1'b0;
    #(CLK_PERIOD * 3);
    check_all("R1");
    chk_pend("R1", 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
    chk_pend("R1", 3'b000);

    // R2 write and read back, unmapped reads
    wr(8'h36, 8'h5C); wr(8'h18, 8'hC1); wr(8'h3E, 8'h0B);
    check_all("R2");
    rd(8'h17, d); chk("R2", "kick read", d, 8'h00);
    rd(8'h20, d); chk("R2", "unmapped read", d, 8'h00);

    // R3 reserved and low bits ignored
    wr(8'h17, 8'h8F);
    chk_pend("R3", 3'b000);
    @(negedge clk);
    check_all("R3");

    // R4 soft-reset release
    wr(8'h3E, 8'hA6);
    wr(8'h17, 8'h40);
    chk_pend("R3", 3'b100);
    @(negedge clk);
    chk_pend("R4", 3'b000);
    m_devc = 8'hA2;
    check_all("R4");

    // R6 seek without busy bracket
    wr(8'h18, 8'h00); wr(8'h37, 8'hA0);
    wr(8'h17, 8'h20);
    chk_pend("R3", 3'b010);
    chk_stat("R6", 8'hA0);
    @(negedge clk);
    chk_pend("R6", 3'b000);
    chk_stat("R6", 8'hB0);
    m_task[6] = 8'hB0;

    // R5 busy-bracketed seek
    wr(8'h18, 8'h02); wr(8'h37, 8'h03);
    wr(8'h17, 8'h20);
    chk_stat("R5", 8'h03);
    @(negedge clk); chk_stat("R5", 8'h83); chk_pend("R5", 3'b010);
    @(negedge clk); chk_stat("R5", 8'h93); chk_pend("R5", 3'b010);
    @(negedge clk); chk_stat("R5", 8'h13); chk_pend("R5", 3'b010);
    @(negedge clk); chk_pend("R5", 3'b000);
    m_task[6] = 8'h13;
    check_all("R5");

    // R7 signature
    wr(8'h36, 8'hA5); wr(8'h37, 8'hFF); wr(8'h31, 8'h3C); wr(8'h34, 8'h66);
    wr(8'h17, 8'h10);
    chk_pend("R3", 3'b001);
    @(negedge clk);
    chk_pend("R7", 3'b000);
    for (int i = 0; i < 7; i++) m_task[i] = sig_exp(i, m_task[i]);
    check_all("R7");

    // R8 priority: all three kicks together
    wr(8'h18, 8'h02); wr(8'h3E, 8'h04); wr(8'h37, 8'h5A); wr(8'h34, 8'h77);
    wr(8'h17, 8'h70);
    chk_pend("R8", 3'b111);
    @(negedge clk);
    chk_pend("R8", 3'b011);
    rd(8'h3E, d); chk("R8", "devctl first", d, 8'h00);
    rd(8'h34, d); chk("R8", "bcl untouched", d, 8'h77);
    @(negedge clk);
    chk_pend("R8", 3'b010);
    rd(8'h34, d); chk("R8", "bcl second", d, 8'h14);
    chk_stat("R8", 8'h10);
    @(negedge clk); chk_stat("R8", 8'h90);
    @(negedge clk); chk_stat("R8", 8'h90);
    @(negedge clk); chk_stat("R8", 8'h10); chk_pend("R8", 3'b010);
    @(negedge clk); chk_pend("R8", 3'b000);
    m_devc = 8'h00;
    for (int i = 0; i < 7; i++) m_task[i] = sig_exp(i, m_task[i]);
    m_task[6] = 8'h10;
    check_all("R8");

    // R9 collision: write 33h in the cycle the signature loads
    @(negedge clk);
    cpu_addr = 8'h17; cpu_wdata = 8'h10; cpu_we = 1'b1;
    @(negedge clk);
    cpu_addr = 8'h33; cpu_wdata = 8'hAA;
    @(negedge clk);
    cpu_we = 1'b0;
    rd(8'h33, d); chk("R9", "sector number", d, 8'h01);
    for (int i = 0; i < 7; i++) m_task[i] = sig_exp(i, m_task[i]);
    check_all("R9");

    // seeded random mix of writes and kicks
    for (int n = 0; n < 80; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 5) begin
        int k;
        logic [7:0] a;
        k = $urandom_range(0, 8);
        a = (k < 7) ? 8'h31 + 8'(k) : ((k == 7) ? 8'h18 : 8'h3E);
        wr(a, 8'($urandom));
        check_all("R2");
      end else if (op == 6) begin
        wr(8'h17, 8'h10);
        @(negedge clk);
        for (int i = 0; i < 7; i++) m_task[i] = sig_exp(i, m_task[i]);
        check_all("R7");
      end else if (op == 7) begin
        wr(8'h17, 8'h20);
        repeat (4) @(negedge clk);
        m_task[6] = seek_exp(m_task[6], m_mode[1]);
        chk_pend("R5", 3'b000);
        check_all("R5");
      end else if (op == 8) begin
        wr(8'h17, 8'h40);
        @(negedge clk);
        m_devc[2] = 1'b0;
        check_all("R4");
      end else begin
        wr(8'h17, {1'b1, 3'b000, 4'($urandom)});
        chk_pend("R3", 3'b000);
        @(negedge clk);
        check_all("R3");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule